// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides, per incoming Ethernet frame, whether the frame is kept or dropped. The decision depends on the frame's 48-bit destination address and on a small set of filter settings. It first sorts the destination into broadcast, multicast or unicast. It then applies that class's acceptance rule. A unicast frame may be compared against one stored station address.

The settings are loaded through a narrow write port. That port has four targets: a control word, a station-entry enable word, and two words that together form the station address. A frame is presented as one destination address with a valid strobe. One cycle later the block returns an accept flag and a reason code that explains a rejection.

Only one station entry exists. The enable readback is a vector with one bit per nominal entry, and every bit above bit 0 reads as zero.

Top module: `eaf_rx_filter`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. When `out_valid` is low, `out_accept` is 0 and `out_reason` is 0.
- R2: A destination of all ones is broadcast. Any other destination with the group bit set is multicast. The group bit is bit 40 of `in_dst`, the lowest bit of the first byte, which sits in bits 47:40. Every other destination is unicast.
- R3: Control bits are written with `cfg_wr_sel`=0: bit 0 accept-all-unicast, bit 1 accept-multicast, bit 2 accept-broadcast, bit 3 compare-enable, bit 4 complement. A broadcast frame is accepted when complement is set, and otherwise only when accept-broadcast is set.
- R4: A multicast frame is accepted when complement is set, and otherwise only when accept-multicast is set.
- R5: A unicast frame is always accepted when accept-all-unicast is set, whatever the address or the other bits.
- R6: Otherwise a unicast frame matches only when compare-enable is set, the entry enable is set, and `in_dst` equals the station address in all 48 bits. Without complement, a match is accepted and a non-match is rejected.
- R7: With complement set and accept-all-unicast clear, the unicast result is inverted: a match is rejected and a non-match is accepted.
- R8: A write with `cfg_wr_sel`=2 loads station address bits 47:16 from the 32-bit data, most significant byte first. A write with `cfg_wr_sel`=3 loads bits 15:0 from data bits 31:16. A write to one half leaves the other half unchanged.
- R9: A write with `cfg_wr_sel`=1 keeps only data bit 0 as the entry enable. `entry_en_rd` shows that bit at bit 0, and its upper bits are always zero.
- R10: The reason code is 0 on acceptance. On rejection it is 1 for broadcast disabled, 2 for multicast disabled, 3 for unicast no match, and 4 for a unicast match rejected by complement.
- R11: After reset all settings are zero, `out_valid` is low, and `entry_en_rd` is zero.
- R12: A setting written in the same cycle as a frame does not affect that frame. It applies to frames presented from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Settings write strobe |
| cfg_wr_sel | input | 2 | Write target: 0 control, 1 enable, 2 address high, 3 address low |
| cfg_wr_data | input | 32 | Write data |
| in_valid | input | 1 | Destination address valid |
| in_dst | input | 48 | Destination address, first byte in bits 47:40 |
| out_valid | output | 1 | Decision valid |
| out_accept | output | 1 | Frame accepted |
| out_reason | output | 3 | Rejection reason, 0 when accepted |
| entry_en_rd | output | 16 | Entry enable readback, upper bits zero |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing and the quiet outputs when no decision is pending;
- that an accepted decision always carries reason 0;
- that a broadcast under complement is always accepted;
- that a unicast with compare, complement and accept-all-unicast all clear is always rejected;
- the enable readback after each write.

Some behaviours need the bench's scenarios because they depend on the stored station address and on sequences of writes:
- exact 48-bit equality and near-miss addresses;
- the split loading of the address;
- the inverted unicast outcome;
- the rule that a write in the same cycle as a frame does not affect that frame.

// File: rtl/eaf_pkg.sv
package eaf_pkg;

    // Control word, bit 4 down to bit 0.
    typedef struct packed {
        logic complement;
        logic cmp_en;
        logic acc_bcast;
        logic acc_mcast;
        logic acc_all_ucast;
    } filt_ctrl_t;

    typedef enum logic [2:0] {
        RSN_PASS      = 3'd0,
        RSN_BCAST_OFF = 3'd1,
        RSN_MCAST_OFF = 3'd2,
        RSN_NO_MATCH  = 3'd3,
        RSN_CMP_MATCH = 3'd4
    } reason_t;

    typedef enum logic [1:0] {
        CLS_UCAST = 2'd0,
        CLS_MCAST = 2'd1,
        CLS_BCAST = 2'd2
    } dst_class_t;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_EN      = 2'd1,
        SEL_ADDR_HI = 2'd2,
        SEL_ADDR_LO = 2'd3
    } cfg_sel_t;

    typedef struct packed {
        logic    valid;
        logic    accept;
        reason_t reason;
    } verdict_t;

endpackage

// File: rtl/eaf_cfg_regs.sv
module eaf_cfg_regs
    import eaf_pkg::*;
#(
    parameter int ADDR_W      = 48,
    parameter int DATA_W      = 32,
    parameter int NUM_ENTRIES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [1:0]             wr_sel,
    input  logic [DATA_W-1:0]      wr_data,
    output filt_ctrl_t             ctrl,
    output logic                   entry_en,
    output logic [ADDR_W-1:0]      station,
    output logic [NUM_ENTRIES-1:0] entry_en_rd
);
    localparam int LO_W   = ADDR_W - DATA_W;
    localparam int CTRL_W = $bits(filt_ctrl_t);

    typedef struct packed {
        filt_ctrl_t        ctrl;
        logic              en;
        logic [ADDR_W-1:0] station;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (cfg_sel_t'(wr_sel))
                SEL_CTRL:    st_d.ctrl = filt_ctrl_t'(wr_data[CTRL_W-1:0]);
                SEL_EN:      st_d.en = wr_data[0];
                SEL_ADDR_HI: st_d.station[ADDR_W-1:LO_W] = wr_data;
                SEL_ADDR_LO: st_d.station[LO_W-1:0] = wr_data[DATA_W-1:DATA_W-LO_W];
                default:     st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl        = st_q.ctrl;
    assign entry_en    = st_q.en;
    assign station     = st_q.station;
    assign entry_en_rd = {{(NUM_ENTRIES-1){1'b0}}, st_q.en};

    // R9: only data bit 0 of an enable write survives in the readback.
    a_r9_enable_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1) |=> (entry_en_rd == {{(NUM_ENTRIES-1){1'b0}}, $past(wr_data[0])}));

endmodule

// File: rtl/eaf_classify.sv
module eaf_classify
    import eaf_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic [ADDR_W-1:0] dst,
    output dst_class_t        cls
);
    localparam int GROUP_BIT = ADDR_W - 8;

    always_comb begin
        if (&dst)                cls = CLS_BCAST;
        else if (dst[GROUP_BIT]) cls = CLS_MCAST;
        else                     cls = CLS_UCAST;
    end
endmodule

// File: rtl/eaf_decide.sv
module eaf_decide
    import eaf_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  dst_class_t        cls,
    input  filt_ctrl_t        ctrl,
    input  logic              entry_en,
    input  logic [ADDR_W-1:0] dst,
    input  logic [ADDR_W-1:0] station,
    output logic              accept,
    output reason_t           reason
);
    logic hit;

    always_comb begin
        hit    = ctrl.cmp_en && entry_en && (dst == station);
        accept = 1'b0;
        reason = RSN_PASS;
        case (cls)
            CLS_BCAST: begin
                accept = ctrl.complement || ctrl.acc_bcast;
                if (!accept) reason = RSN_BCAST_OFF;
            end
            CLS_MCAST: begin
                accept = ctrl.complement || ctrl.acc_mcast;
                if (!accept) reason = RSN_MCAST_OFF;
            end
            default: begin
                if (ctrl.acc_all_ucast) begin
                    accept = 1'b1;
                end else if (ctrl.complement) begin
                    accept = !hit;
                    if (hit) reason = RSN_CMP_MATCH;
                end else begin
                    accept = hit;
                    if (!hit) reason = RSN_NO_MATCH;
                end
            end
        endcase
    end
endmodule

// File: rtl/eaf_rx_filter.sv
module eaf_rx_filter
    import eaf_pkg::*;
#(
    parameter int ADDR_W      = 48,
    parameter int DATA_W      = 32,
    parameter int NUM_ENTRIES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr_en,
    input  logic [1:0]             cfg_wr_sel,
    input  logic [DATA_W-1:0]      cfg_wr_data,
    input  logic                   in_valid,
    input  logic [ADDR_W-1:0]      in_dst,
    output logic                   out_valid,
    output logic                   out_accept,
    output logic [2:0]             out_reason,
    output logic [NUM_ENTRIES-1:0] entry_en_rd
);
    localparam int GROUP_BIT = ADDR_W - 8;

    filt_ctrl_t        ctrl;
    logic              entry_en;
    logic [ADDR_W-1:0] station;
    dst_class_t        cls;
    logic              dec_accept;
    reason_t           dec_reason;
    verdict_t          vd_d, vd_q;

    eaf_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_ENTRIES(NUM_ENTRIES)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel),
        .wr_data(cfg_wr_data), .ctrl(ctrl), .entry_en(entry_en),
        .station(station), .entry_en_rd(entry_en_rd)
    );

    eaf_classify #(.ADDR_W(ADDR_W)) u_cls (.dst(in_dst), .cls(cls));

    eaf_decide #(.ADDR_W(ADDR_W)) u_dec (
        .cls(cls), .ctrl(ctrl), .entry_en(entry_en), .dst(in_dst),
        .station(station), .accept(dec_accept), .reason(dec_reason)
    );

    always_comb begin
        vd_d = '0;
        if (in_valid) begin
            vd_d.valid  = 1'b1;
            vd_d.accept = dec_accept;
            vd_d.reason = dec_reason;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vd_q <= '0;
        else        vd_q <= vd_d;
    end

    assign out_valid  = vd_q.valid;
    assign out_accept = vd_q.accept;
    assign out_reason = vd_q.reason;

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_accept && out_reason == 3'd0));
    a_r10_accept_no_reason: assert property (@(posedge clk) disable iff (!rst_n)
        out_accept |-> (out_reason == 3'd0));
    a_r3_bcast_complement: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&in_dst) && ctrl.complement) |=> out_accept);
    a_r6_no_compare_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_dst[GROUP_BIT] && !ctrl.acc_all_ucast && !ctrl.complement && !ctrl.cmp_en)
        |=> (!out_accept && out_reason == 3'd3));

endmodule

// File: tb/eaf_rx_filter_bench.sv
module eaf_rx_filter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        in_valid = 1'b0;
    logic [47:0] in_dst = '0;
    logic        out_valid, out_accept;
    logic [2:0]  out_reason;
    logic [15:0] entry_en_rd;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference settings.
    logic [4:0]  m_ctrl = '0;
    logic        m_en = 1'b0;
    logic [47:0] m_sta = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eaf_rx_filter u_eaf_rx_filter (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .in_valid(in_valid), .in_dst(in_dst),
        .out_valid(out_valid), .out_accept(out_accept), .out_reason(out_reason),
        .entry_en_rd(entry_en_rd)
    );

    task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] model(input logic [47:0] d);
        logic hit;
        logic acc;
        logic [2:0] rsn;
        hit = m_ctrl[3] && m_en && (d == m_sta);
        rsn = 3'd0;
        if (&d) begin
            acc = m_ctrl[4] || m_ctrl[2];
            if (!acc) rsn = 3'd1;
        end else if (d[40]) begin
            acc = m_ctrl[4] || m_ctrl[1];
            if (!acc) rsn = 3'd2;
        end else if (m_ctrl[0]) begin
            acc = 1'b1;
        end else if (m_ctrl[4]) begin
            acc = !hit;
            if (hit) rsn = 3'd4;
        end else begin
            acc = hit;
            if (!hit) rsn = 3'd3;
        end
        return {acc, rsn};
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        case (sel)
            2'd0: m_ctrl = data[4:0];
            2'd1: m_en = data[0];
            2'd2: m_sta[47:16] = data;
            default: m_sta[15:0] = data[31:16];
        endcase
    endtask

    task automatic frame(input logic [47:0] d, input string req);
        logic [3:0] e;
        @(negedge clk);
        e = model(d);
        in_valid = 1'b1; in_dst = d;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1, {req, " R1 valid"}, 48'(out_valid), 48'd1);
        check({out_accept, out_reason} === e, req, 48'({out_accept, out_reason}), 48'(e));
    endtask

    function automatic logic [47:0] pick_dst(input int k);
        logic [47:0] d;
        d = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
        case (k % 5)
            0: d = '1;
            1: d[40] = 1'b1;
            2: d = m_sta;
            3: d = m_sta ^ (48'd1 << ($urandom % 48));
            default: d[40] = 1'b0;
        endcase
        return d;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(out_valid === 1'b0, "R11 out_valid", 48'(out_valid), 48'd0);
        check(entry_en_rd === 16'd0, "R11 entry_en_rd", 48'(entry_en_rd), 48'd0);
        frame('1, "R11 R3 bcast rejected after reset");
        frame(48'h0100_0000_0000, "R11 R4 mcast rejected after reset");
        frame(48'h0000_0000_0000, "R11 R6 ucast rejected after reset");
        @(negedge clk);
        check(out_valid === 1'b0 && out_reason === 3'd0, "R1 idle outputs", 48'({out_valid, out_reason}), 48'd0);

        // R9 enable keeps bit 0 only
        cfg_write(2'd1, 32'hFFFF_FFFF);
        check(entry_en_rd === 16'h0001, "R9 enable readback", 48'(entry_en_rd), 48'h1);
        cfg_write(2'd1, 32'hFFFF_FFFE);
        check(entry_en_rd === 16'h0000, "R9 enable bit0 clear", 48'(entry_en_rd), 48'h0);
        cfg_write(2'd1, 32'd1);

        // R8 address load, R6 exact match
        cfg_write(2'd2, 32'h0211_2233);
        cfg_write(2'd3, 32'h4455_ABCD);
        cfg_write(2'd0, 32'h0000_0008);
        frame(48'h0211_2233_4455, "R8 R6 exact match accepted");
        frame(48'h0211_2233_4454, "R6 near miss rejected");
        cfg_write(2'd3, 32'h6677_0000);
        frame(48'h0211_2233_6677, "R8 low half reload keeps high");
        cfg_write(2'd1, 32'd0);
        frame(48'h0211_2233_6677, "R6 entry disabled rejects");
        cfg_write(2'd1, 32'd1);
        cfg_write(2'd0, 32'h0000_0000);
        frame(48'h0211_2233_6677, "R6 compare off rejects");

        // R7 complement
        cfg_write(2'd0, 32'h0000_0018);
        frame(48'h0211_2233_6677, "R7 complement match rejected R10");
        frame(48'h0011_2233_6677, "R7 complement miss accepted");
        frame('1, "R3 complement forces bcast");
        frame(48'hFF00_0000_0001, "R4 complement forces mcast");
        // R5 accept-all overrides
        cfg_write(2'd0, 32'h0000_0019);
        frame(48'h0211_2233_6677, "R5 accept all unicast");
        // R2 group bit position
        cfg_write(2'd0, 32'h0000_0002);
        frame(48'h0100_0000_0000, "R2 group bit is mcast");
        frame(48'hFEFF_FFFF_FFFF, "R2 group bit clear is ucast");
        frame(48'hFFFF_FFFF_FFFE, "R2 near broadcast is mcast");

        // R12 same-cycle write ignored by that frame
        cfg_write(2'd0, 32'h0000_0000);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = 2'd0; cfg_wr_data = 32'h4;
        in_valid = 1'b1; in_dst = '1;
        @(negedge clk);
        cfg_wr_en = 1'b0; in_valid = 1'b0; m_ctrl = 5'h04;
        check(out_accept === 1'b0 && out_reason === 3'd1, "R12 same-cycle frame uses old setting",
              48'({out_accept, out_reason}), 48'h1);
        frame('1, "R12 R3 next frame uses new setting");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            if ($urandom % 4 == 0) begin
                int s;
                s = $urandom % 4;
                cfg_write(2'(s), (s == 0) ? ($urandom & 32'h1F) : $urandom);
            end
            frame(pick_dst(int'($urandom % 5)), "R2 R3 R4 R5 R6 R7 R10 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule